// File: doc/BRIEF.md
# Blank-Gated Event Timer

This block is a single 16-bit event timer channel with a small register port. Software selects how the count advances: on every bus clock, on every sixteenth or every 256th bus clock, or once per rising edge of the horizontal blank input. Counting can be qualified by a blank signal. In that case it either runs only while the chosen blank is low, or it is cleared on the rising edge, the falling edge, or both edges of that blank.

The timer compares its count against a programmable target and watches for the count wrapping past its maximum. Either event can latch a sticky flag and raise a one-cycle interrupt request. Software clears the flags by writing ones to them. A target that is programmed at or behind the current count is held inactive until the next wrap, so it cannot fire at once. An optional hold register is plain storage. Channels that omit it read zero at that address.

Top module: `blank_gated_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0, the target reads 0xFFFF, both flags are clear and `irq` is low.
- R2: Address 0 selects the count, 1 the control word, 2 the target and 3 the hold register. Every read returns the 16-bit value in bits 15:0 and zeros in bits 31:16. The hold register reads 0 when the channel has no hold register.
- R3: Control bit 7 enables counting. Control bits 1:0 select the tick source: 0 advances on every clock, 1 every 16 clocks, 2 every 256 clocks, and 3 on each rising hblank edge. For sources 1 and 2 the first tick comes 16 or 256 clocks after the control write.
- R4: A control write stores bits 9:0 as written. It clears the target flag (bit 10) and the overflow flag (bit 11) only where the written data has a 1. A cycle that carries any register write neither counts nor clears.
- R5: With gating enabled (bit 2) in gate mode 0 (bits 5:4), the timer counts only while the gate signal is low. Bit 3 selects the gate signal: 0 for hblank, 1 for vblank.
- R6: Gate modes 1, 2 and 3 clear the count on the rising edge, on the falling edge, or on both edges of the gate signal. A clear takes priority over a tick in the same cycle, and it re-arms the target.
- R7: When gating is enabled with hblank as both the gate signal and the tick source, the timer neither counts nor clears.
- R8: When an armed target is reached and bit 8 is set, the target flag is set. `irq` pulses only if that flag was previously clear.
- R9: On a target hit with zero-return (bit 6) set, the count continues from the count minus the target. Without zero-return, the target is disarmed and counting continues.
- R10: A tick at 0xFFFF wraps the count to 0 and re-arms the target. If bit 9 is set, it also sets the overflow flag, and `irq` pulses if that flag was clear.
- R11: Writing a count at or above the target, or writing a target at or below the count, disarms the target until the next wrap or gate clear.
- R12: `irq` is high for exactly one clock, in the cycle after the edge that newly set a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| hblank | input | 1 | Horizontal blank level |
| vblank | input | 1 | Vertical blank level |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench attacks the target arming rules. It writes a count and a target that leave the target behind the count, and checks that no flag or interrupt appears. A design that compared without an arm bit would interrupt immediately. It also steps the count across 0xFFFF and checks that the target fires after the wrap, which a design that forgot to re-arm would never do. It drives a gate edge and a tick in the same cycle, where a wrong priority leaves a count of 1 instead of 0. It selects hblank as both gate and clock in clear-on-both-edges mode, where a design missing that exclusion would count or clear. Repeated zero-return hits check that a second hit with the flag still set raises no new interrupt.

// File: rtl/bgt_pkg.sv
`timescale 1ns/1ps
package bgt_pkg;
  typedef enum logic [1:0] {
    SRC_BUS    = 2'd0,
    SRC_DIV16  = 2'd1,
    SRC_DIV256 = 2'd2,
    SRC_HBLANK = 2'd3
  } clk_sel_e;

  typedef enum logic [1:0] {
    GM_LEVEL     = 2'd0,
    GM_CLR_START = 2'd1,
    GM_CLR_END   = 2'd2,
    GM_CLR_BOTH  = 2'd3
  } gate_mode_e;

  // Packed MSB first: ovfIe is bit 9, clkSel is bits 1:0
  typedef struct packed {
    logic       ovfIe;
    logic       tgtIe;
    logic       cntEn;
    logic       zeroRet;
    gate_mode_e gateMode;
    logic       gateSrc;
    logic       gateEn;
    clk_sel_e   clkSel;
  } mode_t;

  // Control to datapath strobes
  typedef struct packed {
    logic inc;
    logic clr;
  } strobe_t;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_MODE   = 2'd1;
  localparam logic [1:0] ADDR_TARGET = 2'd2;
  localparam logic [1:0] ADDR_HOLD   = 2'd3;
endpackage

// File: rtl/bgt_ctrl.sv
`timescale 1ns/1ps
module bgt_ctrl
  import bgt_pkg::*;
#(
  parameter int PRE_W   = 8,
  parameter int MID_LOG = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hblank,
  input  logic    vblank,
  input  mode_t   mode,
  input  logic    modeWr,
  input  logic    busy,
  output strobe_t stb
);
  localparam logic [PRE_W-1:0] MID_MASK = PRE_W'((1 << MID_LOG) - 1);

  logic             hbPrev, vbPrev;
  logic [PRE_W-1:0] pre;
  logic             hbRise, gateLvl, gatePrev, gRise, gFall;
  logic             tick, dead, levelOk, clrEv, live;
  logic             unusedMode;

  assign unusedMode = mode.zeroRet ^ mode.tgtIe ^ mode.ovfIe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hbPrev <= 1'b0;
      vbPrev <= 1'b0;
      pre    <= '0;
    end else begin
      hbPrev <= hblank;
      vbPrev <= vblank;
      pre    <= modeWr ? '0 : pre + 1'b1;
    end
  end

  assign hbRise   = hblank & ~hbPrev;
  assign gateLvl  = mode.gateSrc ? vblank : hblank;
  assign gatePrev = mode.gateSrc ? vbPrev : hbPrev;
  assign gRise    = gateLvl & ~gatePrev;
  assign gFall    = ~gateLvl & gatePrev;

  always_comb begin
    unique case (mode.clkSel)
      SRC_BUS:    tick = 1'b1;
      SRC_DIV16:  tick = ((pre & MID_MASK) == MID_MASK);
      SRC_DIV256: tick = &pre;
      default:    tick = hbRise;
    endcase
  end

  always_comb begin
    clrEv = 1'b0;
    if (mode.gateEn) begin
      unique case (mode.gateMode)
        GM_CLR_START: clrEv = gRise;
        GM_CLR_END:   clrEv = gFall;
        GM_CLR_BOTH:  clrEv = gRise | gFall;
        default:      clrEv = 1'b0;
      endcase
    end
  end

  assign dead    = mode.gateEn & ~mode.gateSrc & (mode.clkSel == SRC_HBLANK);
  assign levelOk = !(mode.gateEn && mode.gateMode == GM_LEVEL && gateLvl);
  assign live    = mode.cntEn & ~dead & ~busy;

  assign stb.clr = live & clrEv;
  assign stb.inc = live & tick & levelOk & ~clrEv;
endmodule

// File: rtl/bgt_datapath.sv
`timescale 1ns/1ps
module bgt_datapath
  import bgt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit HAS_HOLD = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output mode_t            modeQ,
  output logic [CNT_W-1:0] countQ,
  output logic             tgtFlagQ,
  output logic             ovfFlagQ,
  output logic             irq
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam int PAD_W = 32 - CNT_W;

  logic [CNT_W-1:0] targetQ, holdVal, wdVal;
  logic             armedQ;
  logic [CNT_W-1:0] nCount;
  logic             nArmed, nTgtF, nOvfF, newFlag;
  logic             unusedHi;

  assign wdVal    = regWdata[CNT_W-1:0];
  assign unusedHi = ^regWdata[31:CNT_W];

  // Event update: clear wins, then tick with wrap, then target test
  always_comb begin
    nCount  = countQ;
    nArmed  = armedQ;
    nTgtF   = tgtFlagQ;
    nOvfF   = ovfFlagQ;
    newFlag = 1'b0;
    if (stb.clr) begin
      nCount = '0;
      nArmed = 1'b1;
    end else if (stb.inc) begin
      if (countQ == MAXV) begin
        nCount = '0;
        nArmed = 1'b1;
        if (modeQ.ovfIe) begin
          nOvfF   = 1'b1;
          newFlag = ~ovfFlagQ;
        end
      end else begin
        nCount = countQ + 1'b1;
      end
      if (nArmed && nCount >= targetQ) begin
        if (modeQ.tgtIe) begin
          nTgtF   = 1'b1;
          newFlag = newFlag | ~tgtFlagQ;
        end
        if (modeQ.zeroRet) nCount = nCount - targetQ;
        else               nArmed = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= '0;
      targetQ  <= MAXV;
      armedQ   <= 1'b1;
      modeQ    <= '0;
      tgtFlagQ <= 1'b0;
      ovfFlagQ <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= newFlag;
      if (regWe) begin
        unique case (regAddr)
          ADDR_COUNT: begin
            countQ <= wdVal;
            armedQ <= (wdVal < targetQ);
          end
          ADDR_MODE: begin
            modeQ    <= mode_t'(regWdata[9:0]);
            tgtFlagQ <= tgtFlagQ & ~regWdata[10];
            ovfFlagQ <= ovfFlagQ & ~regWdata[11];
          end
          ADDR_TARGET: begin
            targetQ <= wdVal;
            armedQ  <= (wdVal > countQ);
          end
          default: ;
        endcase
      end else begin
        countQ   <= nCount;
        armedQ   <= nArmed;
        tgtFlagQ <= nTgtF;
        ovfFlagQ <= nOvfF;
      end
    end
  end

  generate
    if (HAS_HOLD) begin : g_hold
      logic [CNT_W-1:0] holdQ;
      always_ff @(posedge clk) begin
        if (!rstN) holdQ <= '0;
        else if (regWe && regAddr == ADDR_HOLD) holdQ <= wdVal;
      end
      assign holdVal = holdQ;
    end else begin : g_noHold
      assign holdVal = '0;
    end
  endgenerate

  always_comb begin
    unique case (regAddr)
      ADDR_COUNT:  regRdata = {{PAD_W{1'b0}}, countQ};
      ADDR_MODE:   regRdata = {20'd0, ovfFlagQ, tgtFlagQ, modeQ};
      ADDR_TARGET: regRdata = {{PAD_W{1'b0}}, targetQ};
      default:     regRdata = {{PAD_W{1'b0}}, holdVal};
    endcase
  end
endmodule

// File: rtl/blank_gated_timer.sv
`timescale 1ns/1ps
module blank_gated_timer
  import bgt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int MID_LOG  = 4,
  parameter bit HAS_HOLD = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hblank,
  input  logic        vblank,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irq
);
  strobe_t          stb;
  mode_t            modeQ;
  logic [CNT_W-1:0] countQ;
  logic             tgtFlagQ, ovfFlagQ;
  logic             modeWr;

  assign modeWr = regWe && (regAddr == ADDR_MODE);

  bgt_ctrl #(.PRE_W(PRE_W), .MID_LOG(MID_LOG)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .hblank (hblank),
    .vblank (vblank),
    .mode   (modeQ),
    .modeWr (modeWr),
    .busy   (regWe),
    .stb    (stb)
  );

  bgt_datapath #(.CNT_W(CNT_W), .HAS_HOLD(HAS_HOLD)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .modeQ    (modeQ),
    .countQ   (countQ),
    .tgtFlagQ (tgtFlagQ),
    .ovfFlagQ (ovfFlagQ),
    .irq      (irq)
  );
endmodule

// File: rtl/bgt_checker.sv
`timescale 1ns/1ps
module bgt_checker
  import bgt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [31:0]      regRdata,
  input logic             irq,
  input mode_t            mode,
  input strobe_t          stb,
  input logic [CNT_W-1:0] count,
  input logic             tgtFlag,
  input logic             ovfFlag
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[31:16] == 16'd0);

  a_r3_enable_gates: assert property (@(posedge clk) disable iff (!rstN)
    !mode.cntEn |-> (!stb.inc && !stb.clr));

  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.inc && !stb.clr && !regWe) |=> $stable(count));

  a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (!stb.inc && !stb.clr));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (count == '0));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.inc && stb.clr));

  a_r7_dead_combo: assert property (@(posedge clk) disable iff (!rstN)
    (mode.gateEn && !mode.gateSrc && mode.clkSel == SRC_HBLANK) |-> (!stb.inc && !stb.clr));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (tgtFlag && !regWe) |=> tgtFlag);

  a_r10_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc && count == {CNT_W{1'b1}}) |=> (count == '0));

  a_r12_irq_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (tgtFlag || ovfFlag));
endmodule

bind blank_gated_timer bgt_checker #(.CNT_W(CNT_W)) u_bgtChk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regRdata (regRdata),
  .irq      (irq),
  .mode     (modeQ),
  .stb      (stb),
  .count    (countQ),
  .tgtFlag  (tgtFlagQ),
  .ovfFlag  (ovfFlagQ)
);

// File: tb/blank_gated_timer_bench.sv
`timescale 1ns/1ps
module blank_gated_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hblank = 1'b0;
  logic        vblank = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  sampleEv;

  localparam logic [1:0] A_CNT = 2'd0, A_MODE = 2'd1, A_TGT = 2'd2, A_HOLD = 2'd3;

  always #2.5 clk = ~clk;

  blank_gated_timer u_blank_gated_timer (
    .clk      (clk),
    .rstN     (rstN),
    .hblank   (hblank),
    .vblank   (vblank),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .irq      (irq)
  );

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        item_t       it;
        logic [31:0] act;
        it  = q.pop_front();
        act = (it.kind == 0) ? regRdata : {31'd0, irq};
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = e;
    it.tag  = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic chkRead(input logic [1:0] a, input logic [31:0] e, input string tag);
    regAddr = a;
    #1;
    push(0, e, tag);
    -> sampleEv;
    @(negedge clk);
  endtask

  task automatic pulse(input logic expIrq, input string tag);
    hblank = 1'b1;
    @(negedge clk);
    push(1, {31'd0, expIrq}, tag);
    -> sampleEv;
    hblank = 1'b0;
    @(negedge clk);
    push(1, 32'd0, "R12 irq one cycle");
    -> sampleEv;
  endtask

  task automatic setVb(input logic v);
    vblank = v;
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkRead(A_CNT, 32'h0, "R1 count");
    chkRead(A_MODE, 32'h0, "R1 mode");
    chkRead(A_TGT, 32'h0000FFFF, "R1 target");
    chkRead(A_HOLD, 32'h0, "R2 hold reset");
    push(1, 32'd0, "R1 irq low"); -> sampleEv; @(negedge clk);

    // R2 hold storage, upper half zero
    wr(A_HOLD, 32'h1234ABCD);
    chkRead(A_HOLD, 32'h0000ABCD, "R2 hold upper zero");

    // R3 hblank tick source, R4 mode store
    wr(A_MODE, 32'h083);
    chkRead(A_MODE, 32'h083, "R4 mode stored");
    for (int i = 0; i < 5; i++) pulse(1'b0, "R3 no irq");
    chkRead(A_CNT, 32'd5, "R3 hblank ticks");
    wr(A_MODE, 32'h003);
    for (int i = 0; i < 3; i++) pulse(1'b0, "R3 no irq");
    chkRead(A_CNT, 32'd5, "R3 count disabled");

    // R3 bus clock source
    wr(A_MODE, 32'h080);
    repeat (10) @(negedge clk);
    wr(A_MODE, 32'h003);
    chkRead(A_CNT, 32'd15, "R3 every clock");

    // R3 divide by 16
    wr(A_CNT, 32'd0);
    wr(A_MODE, 32'h081);
    repeat (39) @(negedge clk);
    wr(A_MODE, 32'h003);
    chkRead(A_CNT, 32'd2, "R3 div16");

    // R3 divide by 256
    wr(A_CNT, 32'd0);
    wr(A_MODE, 32'h082);
    repeat (599) @(negedge clk);
    wr(A_MODE, 32'h003);
    chkRead(A_CNT, 32'd2, "R3 div256");

    // R8 target hit, R9 no zero-return disarms
    wr(A_CNT, 32'd0);
    wr(A_TGT, 32'd3);
    wr(A_MODE, 32'h183);
    pulse(1'b0, "R8 before target");
    pulse(1'b0, "R8 before target");
    pulse(1'b1, "R8 target irq");
    chkRead(A_MODE, 32'h583, "R8 target flag");
    chkRead(A_CNT, 32'd3, "R9 count kept");
    pulse(1'b0, "R9 disarmed");
    pulse(1'b0, "R9 disarmed");
    chkRead(A_CNT, 32'd5, "R9 counts on");

    // R9 zero-return, R8 no retrigger while flag set
    wr(A_MODE, 32'h5C3);
    chkRead(A_MODE, 32'h1C3, "R4 flag cleared by 1");
    wr(A_CNT, 32'd0);
    pulse(1'b0, "R9 zr");
    pulse(1'b0, "R9 zr");
    pulse(1'b1, "R9 zr hit irq");
    chkRead(A_CNT, 32'd0, "R9 zero return");
    pulse(1'b0, "R9 zr");
    pulse(1'b0, "R9 zr");
    pulse(1'b0, "R8 no irq flag set");
    chkRead(A_CNT, 32'd0, "R9 zero return again");
    chkRead(A_MODE, 32'h5C3, "R8 flag sticky");

    // R10 overflow, R11 count write disarms
    wr(A_MODE, 32'h783);
    chkRead(A_MODE, 32'h383, "R4 flag clear");
    wr(A_TGT, 32'd2);
    wr(A_CNT, 32'hFFFE);
    pulse(1'b0, "R11 count write disarmed");
    chkRead(A_CNT, 32'h0000FFFF, "R11 count max");
    pulse(1'b1, "R10 overflow irq");
    chkRead(A_CNT, 32'd0, "R10 wrap");
    chkRead(A_MODE, 32'hB83, "R10 overflow flag");
    pulse(1'b0, "R10 before target");
    pulse(1'b1, "R10 target rearmed");
    chkRead(A_MODE, 32'hF83, "R10 both flags");

    // R11 target written behind count
    wr(A_MODE, 32'hF83);
    chkRead(A_MODE, 32'h383, "R4 both flags cleared");
    wr(A_TGT, 32'd1);
    pulse(1'b0, "R11 target behind");
    pulse(1'b0, "R11 target behind");
    chkRead(A_CNT, 32'd4, "R11 count");
    chkRead(A_MODE, 32'h383, "R11 no flag");

    // R5 gate mode 0 on vblank
    wr(A_MODE, 32'h08F);
    wr(A_CNT, 32'd0);
    setVb(1'b1);
    pulse(1'b0, "R5 gated");
    pulse(1'b0, "R5 gated");
    chkRead(A_CNT, 32'd0, "R5 blocked while high");
    setVb(1'b0);
    pulse(1'b0, "R5 open");
    pulse(1'b0, "R5 open");
    chkRead(A_CNT, 32'd2, "R5 counts while low");

    // R6 gate mode 1
    wr(A_MODE, 32'h09F);
    for (int i = 0; i < 3; i++) pulse(1'b0, "R6 m1");
    chkRead(A_CNT, 32'd5, "R6 m1 pre");
    setVb(1'b1);
    chkRead(A_CNT, 32'd0, "R6 m1 clear on rise");
    pulse(1'b0, "R6 m1");
    pulse(1'b0, "R6 m1");
    chkRead(A_CNT, 32'd2, "R6 m1 counts high");
    setVb(1'b0);
    chkRead(A_CNT, 32'd2, "R6 m1 fall ignored");

    // R6 gate mode 2
    wr(A_MODE, 32'h0AF);
    pulse(1'b0, "R6 m2");
    setVb(1'b1);
    chkRead(A_CNT, 32'd3, "R6 m2 rise ignored");
    setVb(1'b0);
    chkRead(A_CNT, 32'd0, "R6 m2 clear on fall");

    // R6 gate mode 3
    wr(A_MODE, 32'h0BF);
    wr(A_CNT, 32'd7);
    setVb(1'b1);
    chkRead(A_CNT, 32'd0, "R6 m3 rise");
    pulse(1'b0, "R6 m3");
    pulse(1'b0, "R6 m3");
    setVb(1'b0);
    chkRead(A_CNT, 32'd0, "R6 m3 fall");

    // R6 clear wins over a tick in the same cycle
    wr(A_MODE, 32'h09F);
    wr(A_CNT, 32'd9);
    hblank = 1'b1; vblank = 1'b1;
    @(negedge clk);
    hblank = 1'b0;
    @(negedge clk);
    chkRead(A_CNT, 32'd0, "R6 clear priority");
    setVb(1'b0);

    // R6 gate clear re-arms the target
    wr(A_MODE, 32'hD9F);
    chkRead(A_MODE, 32'h19F, "R4 flags cleared");
    wr(A_CNT, 32'd5);
    wr(A_TGT, 32'd2);
    setVb(1'b1);
    setVb(1'b0);
    pulse(1'b0, "R6 rearm");
    pulse(1'b1, "R6 rearmed target irq");

    // R7 hblank as gate and clock
    wr(A_MODE, 32'h0B7);
    wr(A_CNT, 32'd4);
    for (int i = 0; i < 3; i++) pulse(1'b0, "R7 dead");
    chkRead(A_CNT, 32'd4, "R7 no count no clear");

    @(negedge clk);
    if (q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard: actual=%0d expected=0 items left", q.size());
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule